// File: doc/BRIEF.md
# Paired-Byte Event Serializer

This block turns sniffer events into serial messages for a host link. There are two kinds of event: a captured line character, or a change of the reset line. Each event becomes a 16-bit message. The block sends that message as two 8N1 bytes inside one unbroken 20-bit shift-out. The serial line never carries a lone byte. A host that loses its place can therefore drop a half-received pair after a long pause and pick up again on the next pair.

Events enter on a valid/ready stream. The source holds `evt_valid` and its fields steady until a clock edge on which `evt_ready` is also high, and the event is taken on that edge. At that edge the message is captured into the shift register, so the source may change its fields freely afterwards. `evt_ready` stays low for the rest of the frame. It rises only in the last clock of the second stop bit, so a waiting event is taken on the very edge that ends the previous frame. Frames can therefore follow each other with no idle gap. Each bit lasts `CLKS_PER_BIT` system clocks: with 16 clocks at 48 MHz the line runs at 3 Mbit/s.

Top module: `evt_pair_tx`

## Requirements
- R1: After reset, `txd` is 1 and `evt_ready` is 1, and `txd` stays 1 whenever no frame is being sent.
- R2: An accepted event produces exactly one frame of 20 bit periods on `txd`. The frame is start(0), low byte, stop(1), start(0), high byte, stop(1), with each byte sent least significant bit first. There is no gap inside the frame.
- R3: Each bit period lasts exactly `CLKS_PER_BIT` clocks (16 by default). The start bit begins in the clock after the accepting edge.
- R4: For a character event (`evt_is_rst`=0), the low byte is `evt_data`. In the high byte, bit0 is the parity bit, bit1 is the error flag, bit2 is the PPS-action flag, bit6 is 1 and bit7 is 0. Bits 3 to 5 are 0.
- R5: For a reset event (`evt_is_rst`=1), the high byte has bit7=1 and bit6 equal to `evt_rst_level`. Every other message bit is 0, whatever `evt_data`, `evt_parity`, `evt_err` and `evt_pps` hold.
- R6: `evt_ready` is 0 from the clock after acceptance through the clock before the last clock of the second stop bit. It is 1 in that last clock.
- R7: The message is captured at acceptance. Input changes made while the frame is being sent do not alter the frame.
- R8: An event held valid during a frame is accepted on the edge that ends that frame. Its start bit follows the previous stop bit with no idle clock between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_valid | input | 1 | Event offered |
| evt_ready | output | 1 | Block can take an event this cycle |
| evt_is_rst | input | 1 | 1 = reset-line event, 0 = character event |
| evt_rst_level | input | 1 | New reset-line level (reset events only) |
| evt_data | input | 8 | Captured character bits |
| evt_parity | input | 1 | Received parity bit |
| evt_err | input | 1 | Error signal seen during the character |
| evt_pps | input | 1 | PPS-action flag |
| txd | output | 1 | Serial data, idles high |

## Verification
Two things can happen on the same clock edge: the final stop bit ends, and a waiting event is accepted. When they do, the load must win over the shift that would otherwise return the line to idle. The bench provokes this by holding the next event valid for the whole of a frame. It then checks three things: that `evt_ready` stays low for exactly 319 sampled cycles, that the next start bit follows the previous stop bit with no idle clock in between, and that both frames decode to their own expected messages.

// File: rtl/evt_pair_pkg.sv
package evt_pair_pkg;

  localparam int BYTE_W = 8;
  localparam int MSG_W  = 2 * BYTE_W;

  // High-byte flag positions
  localparam int HI_PARITY = 0;
  localparam int HI_ERR    = 1;
  localparam int HI_PPS    = 2;
  localparam int HI_LEVEL  = 6;
  localparam int HI_TYPE   = 7;

  typedef struct packed {
    logic              is_rst;
    logic              rst_level;
    logic [BYTE_W-1:0] data;
    logic              parity;
    logic              err;
    logic              pps;
  } evt_t;

endpackage

// File: rtl/evt_msg_pack.sv
module evt_msg_pack
  import evt_pair_pkg::*;
(
  input  evt_t             evt,
  output logic [MSG_W-1:0] msg
);

  logic [BYTE_W-1:0] lo_byte;
  logic [BYTE_W-1:0] hi_byte;

  always_comb begin
    hi_byte = '0;
    lo_byte = '0;
    hi_byte[HI_TYPE] = evt.is_rst;
    if (evt.is_rst) begin
      hi_byte[HI_LEVEL] = evt.rst_level;
    end else begin
      hi_byte[HI_LEVEL]  = 1'b1;
      hi_byte[HI_PARITY] = evt.parity;
      hi_byte[HI_ERR]    = evt.err;
      hi_byte[HI_PPS]    = evt.pps;
      lo_byte            = evt.data;
    end
    msg = {hi_byte, lo_byte};
  end

endmodule

// File: rtl/evt_baud_div.sv
module evt_baud_div #(
  parameter int CLKS_PER_BIT = 16,
  localparam int CNT_W = (CLKS_PER_BIT > 2) ? $clog2(CLKS_PER_BIT) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  output logic tick
);

  logic [CNT_W-1:0] cnt_q;
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(CLKS_PER_BIT - 1);

  assign tick = run && (cnt_q == CNT_MAX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (restart || !run) begin
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R3
  cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_MAX);

  // R3
  cnt_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> cnt_q == '0);

endmodule

// File: rtl/evt_frame_shift.sv
module evt_frame_shift
  import evt_pair_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [MSG_W-1:0] msg,
  input  logic             tick,
  output logic             txd,
  output logic             busy,
  output logic             last_bit
);

  localparam int SLOT_W  = BYTE_W + 2;
  localparam int FRAME_W = 2 * SLOT_W;
  localparam int IDX_W   = $clog2(FRAME_W);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(FRAME_W - 1);

  logic [FRAME_W-1:0] frame;
  logic [FRAME_W-1:0] shreg_q;
  logic [IDX_W-1:0]   idx_q;
  logic               busy_q;

  // Each byte slot: stop, byte, start (start at LSB side)
  genvar s;
  generate
    for (s = 0; s < 2; s++) begin : g_slot
      assign frame[s*SLOT_W]                   = 1'b0;
      assign frame[s*SLOT_W+1 +: BYTE_W]       = msg[s*BYTE_W +: BYTE_W];
      assign frame[s*SLOT_W+SLOT_W-1]          = 1'b1;
    end
  endgenerate

  assign busy     = busy_q;
  assign last_bit = busy_q && (idx_q == IDX_LAST);
  assign txd      = busy_q ? shreg_q[0] : 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg_q <= '1;
      idx_q   <= '0;
      busy_q  <= 1'b0;
    end else if (load) begin
      shreg_q <= frame;
      idx_q   <= '0;
      busy_q  <= 1'b1;
    end else if (tick) begin
      shreg_q <= {1'b1, shreg_q[FRAME_W-1:1]};
      if (idx_q == IDX_LAST) begin
        busy_q <= 1'b0;
        idx_q  <= '0;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  // R3
  start_after_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (busy && !txd));

  // R1
  idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd);

  // R3
  bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick && !load) |=> $stable(txd));

  // R7
  frame_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick && !load) |=> $stable(shreg_q));

  // R2
  frame_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (last_bit && tick && !load) |=> (!busy && txd));

endmodule

// File: rtl/evt_pair_tx.sv
module evt_pair_tx
  import evt_pair_pkg::*;
#(
  parameter int CLKS_PER_BIT = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_valid,
  output logic              evt_ready,
  input  logic              evt_is_rst,
  input  logic              evt_rst_level,
  input  logic [BYTE_W-1:0] evt_data,
  input  logic              evt_parity,
  input  logic              evt_err,
  input  logic              evt_pps,
  output logic              txd
);

  evt_t             evt;
  logic [MSG_W-1:0] msg;
  logic             accept;
  logic             tick;
  logic             busy;
  logic             last_bit;

  assign evt = '{is_rst: evt_is_rst, rst_level: evt_rst_level, data: evt_data,
                 parity: evt_parity, err: evt_err, pps: evt_pps};

  assign evt_ready = !busy || (last_bit && tick);
  assign accept    = evt_valid && evt_ready;

  evt_msg_pack u_pack (
    .evt (evt),
    .msg (msg)
  );

  evt_baud_div #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (busy),
    .restart (accept),
    .tick    (tick)
  );

  evt_frame_shift u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .msg      (msg),
    .tick     (tick),
    .txd      (txd),
    .busy     (busy),
    .last_bit (last_bit)
  );

  // R6
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !evt_ready);

  // R8
  back_to_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && busy) |=> (busy && !txd));

endmodule

// File: tb/evt_pair_tx_tb.sv
module evt_pair_tx_tb;

  localparam int CLK_PERIOD = 10;
  localparam int BITCLK     = 16;
  localparam int FRAME_CLKS = 20 * BITCLK;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       evt_valid;
  logic       evt_ready;
  logic       evt_is_rst;
  logic       evt_rst_level;
  logic [7:0] evt_data;
  logic       evt_parity;
  logic       evt_err;
  logic       evt_pps;
  logic       txd;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 0;
  logic [15:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  evt_pair_tx #(.CLKS_PER_BIT(BITCLK)) u_dut (
    .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_ready(evt_ready),
    .evt_is_rst(evt_is_rst), .evt_rst_level(evt_rst_level), .evt_data(evt_data),
    .evt_parity(evt_parity), .evt_err(evt_err), .evt_pps(evt_pps), .txd(txd)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG && !done) begin
      done = 1;
      check(0, "watchdog", cyc, WATCHDOG);
      summary();
    end
  end

  function automatic logic [15:0] model(input bit is_rst, input bit lvl, input logic [7:0] d,
                                        input bit p, input bit e, input bit s);
    if (is_rst) return {is_rst, lvl, 6'b0, 8'h00};
    return {1'b0, 1'b1, 3'b000, s, e, p, d};
  endfunction

  // Drive an event; waits for ready and returns after the accepting edge (at negedge).
  task automatic send(input bit is_rst, input bit lvl, input logic [7:0] d,
                      input bit p, input bit e, input bit s, output int wait_cnt);
    evt_valid = 1; evt_is_rst = is_rst; evt_rst_level = lvl; evt_data = d;
    evt_parity = p; evt_err = e; evt_pps = s;
    wait_cnt = 0;
    while (!evt_ready) begin
      @(negedge clk);
      wait_cnt++;
    end
    exp_q.push_back(model(is_rst, lvl, d, p, e, s));
    @(negedge clk);
    evt_valid = 0;
    // R7: scramble inputs after acceptance
    evt_is_rst = ~is_rst; evt_data = ~d; evt_parity = ~p; evt_err = ~e; evt_pps = ~s;
    evt_rst_level = ~lvl;
  endtask

  // Monitor: decodes frames, checks framing and bit timing, compares against queue.
  initial begin
    @(posedge rst_n);
    forever begin
      @(negedge clk);
      if (txd === 1'b0) begin
        logic [19:0] bits;
        bit timing_ok = 1;
        logic [15:0] got;
        logic [15:0] exp;
        bits = '0;
        for (int c = 0; c < FRAME_CLKS; c++) begin
          if (c > 0) @(negedge clk);
          if (c % BITCLK == 8) bits[c / BITCLK] = txd;
          if (c % BITCLK == 15 && txd !== bits[c / BITCLK]) timing_ok = 0;
        end
        // R3: each bit constant across its whole period
        check(timing_ok, "R3 bit period", timing_ok, 1);
        // R2: start/stop positions
        check(bits[0] == 0 && bits[9] == 1 && bits[10] == 0 && bits[19] == 1,
              "R2 framing", {bits[19], bits[10], bits[9], bits[0]}, 4'b1010);
        got = {bits[18:11], bits[8:1]};
        if (exp_q.size() == 0) begin
          check(0, "R2 unexpected frame", got, 0);
        end else begin
          exp = exp_q.pop_front();
          check(got == exp, "R4/R5 message", got, exp);
        end
      end
    end
  end

  initial begin
    int w;
    evt_valid = 0; evt_is_rst = 0; evt_rst_level = 0; evt_data = 0;
    evt_parity = 0; evt_err = 0; evt_pps = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check(txd === 1'b1, "R1 idle txd", txd, 1);
    check(evt_ready === 1'b1, "R1 idle ready", evt_ready, 1);
    repeat (20) @(negedge clk);
    check(txd === 1'b1, "R1 stays idle", txd, 1);

    // R4 character, R6 ready drop
    send(0, 0, 8'hA5, 1, 0, 1, w);
    check(evt_ready === 1'b0, "R6 ready low after accept", evt_ready, 0);
    // R3: start bit begins the clock after acceptance (we are one cycle after it)
    check(txd === 1'b0, "R3 start bit position", txd, 0);
    repeat (FRAME_CLKS + 10) @(negedge clk);
    check(txd === 1'b1, "R1 idle after frame", txd, 1);

    // R5 reset events with junk in character fields
    send(1, 1, 8'hFF, 1, 1, 1, w);
    repeat (FRAME_CLKS + 5) @(negedge clk);
    send(1, 0, 8'h3C, 1, 1, 0, w);
    repeat (FRAME_CLKS + 5) @(negedge clk);

    // R4 flag combinations
    send(0, 0, 8'h00, 0, 1, 0, w);
    repeat (FRAME_CLKS + 3) @(negedge clk);
    send(0, 1, 8'h81, 0, 0, 0, w);
    repeat (FRAME_CLKS + 3) @(negedge clk);

    // R8/R6 back-to-back: second event held during first frame
    send(0, 0, 8'h3B, 1, 1, 1, w);
    send(0, 0, 8'hFF, 0, 0, 0, w);
    check(w == FRAME_CLKS - 1, "R6 ready low span", w, FRAME_CLKS - 1);
    // R8: second start follows first frame without gap (one cycle after accept)
    check(txd === 1'b0, "R8 no gap start", txd, 0);
    send(1, 1, 8'h55, 0, 1, 0, w);
    check(w == FRAME_CLKS - 1, "R8 third back-to-back", w, FRAME_CLKS - 1);
    repeat (FRAME_CLKS + 10) @(negedge clk);

    check(exp_q.size() == 0, "R2 all frames seen", exp_q.size(), 0);
    check(txd === 1'b1, "R1 final idle", txd, 1);
    done = 1;
    summary();
  end

endmodule